// File: doc/BRIEF.md
# Store Queue with Store-to-Load Forwarding

This block holds the stores that an out-of-order core has dispatched but not yet written to the data cache. Each store takes a slot at the tail when it is dispatched. Its address and its data arrive later and separately, as the address and data operations execute. After the reorder logic retires a store, the store drains from the head to the cache in strict program order, one write for each cache acknowledge.

A load issues its address together with its queue position. The position is the tail pointer value, wrap bit included, that the load saw at dispatch. Every store slot is compared with the load address in the same cycle, alongside the cache access. Only stores older than the load take part. The youngest of these decides the result, which is one of three outcomes:
- forward the store's data;
- no forwarding, so the load takes the cache data;
- unknown, when an older store address is unresolved or the matching store has no data yet.

A recovery input moves the tail back to a given pointer and discards every younger store.

Drain state machine: `DR_IDLE` moves to `DR_BUSY` when the head store has retired. `DR_BUSY` holds the cache request. When the cache acknowledges, the head is popped, and the machine stays in `DR_BUSY` if the next store has already retired, otherwise it returns to `DR_IDLE`.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty. `full`, `dc_req` and `alloc_tag` are 0, and a lookup returns outcome 0.
- R2: Each `alloc_en` pulse takes the slot at the tail and advances `alloc_tag` (a 4-bit pointer with a wrap bit) by one. `full` rises when 8 stores are held, and allocation while full leaves `alloc_tag` unchanged.
- R3: A lookup returns outcome 1 and that store's data when the youngest older store whose address equals `ld_addr` has its data.
- R4: Stores at or beyond the load position (same age or younger) never affect the outcome.
- R5: If all older store addresses are known and none equals `ld_addr`, the outcome is 0 (use the cache).
- R6: An older store with an unresolved address gives outcome 2 when it is younger than the youngest matching store. A matching store younger than it still forwards.
- R7: When the youngest older matching store has no data yet, the outcome is 2.
- R8: Retired stores are written to the cache in program order. `dc_req` with its `dc_addr` and `dc_data` stays steady until `dc_ack`, and one store leaves the head for each acknowledge.
- R9: A store that has drained to the cache no longer takes part in lookups.
- R10: `flush_en` sets the tail to `flush_tail` in the next cycle. Stores at or beyond it are discarded, and `full` is recomputed.
- R11: `retire_en` is ignored when every held store has already retired, and an unretired store is never sent to the cache.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Allocate one store slot at the tail |
| alloc_tag | output | 4 | Current tail pointer with wrap bit; the slot the next store receives |
| full | output | 1 | All 8 slots are occupied |
| addr_en | input | 1 | Write a resolved address into a slot |
| addr_idx | input | 3 | Slot receiving the address |
| addr_val | input | 32 | Store address |
| data_en | input | 1 | Write store data into a slot |
| data_idx | input | 3 | Slot receiving the data |
| data_val | input | 32 | Store data |
| retire_en | input | 1 | Mark the oldest unretired store as retired |
| flush_en | input | 1 | Recovery: rewind the tail |
| flush_tail | input | 4 | New tail pointer, with wrap bit |
| ld_addr | input | 32 | Load address to search |
| ld_pos | input | 4 | Tail value the load saw at dispatch |
| ld_outcome | output | 2 | 0 use cache, 1 forward, 2 unknown |
| ld_data | output | 32 | Forwarded data, valid when outcome is 1 |
| dc_req | output | 1 | Cache write request for the head store |
| dc_addr | output | 32 | Cache write address |
| dc_data | output | 32 | Cache write data |
| dc_ack | input | 1 | Cache accepts the write |

## Verification
The hardest situation to reach is a single lookup that contains a resolved match, an unresolved store and a younger match, in several age orders. The stimulus builds a five-store window and leaves one address and one data item missing on purpose. It then moves the load position across that window, so the same stored state produces forward, unknown and use-cache outcomes. A second hard case is a load that targets a discarded slot after a rewind. The bench reaches it by filling the queue and writing a slot that is later discarded. It then rewinds, reallocates that same slot and searches for the old address.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        LD_CACHE = 2'd0,
        LD_FWD   = 2'd1,
        LD_WAIT  = 2'd2
    } ld_outcome_e;

    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_BUSY = 1'b1
    } drain_st_e;
endpackage

// File: rtl/sq_ptr_ctl.sv
module sq_ptr_ctl #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    input  logic          flush_en,
    input  logic [PW:0]   flush_tail,
    input  logic          retire_req,
    input  logic          pop,
    output logic [PW:0]   head,
    output logic [PW:0]   tail,
    output logic [PW:0]   ret,
    output logic          full,
    output logic          alloc_go
);
    logic [PW:0] used;
    logic        retire_go;

    assign used      = tail - head;
    assign full      = (used == (PW+1)'(DEPTH));
    assign alloc_go  = alloc_req && !full && !flush_en;
    assign retire_go = retire_req && (ret != tail);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            ret  <= '0;
        end else begin
            if (flush_en)
                tail <= flush_tail;
            else if (alloc_go)
                tail <= tail + 1'b1;
            if (retire_go)
                ret <= ret + 1'b1;
            if (pop)
                head <= head + 1'b1;
        end
    end
endmodule

// File: rtl/sq_search.sv
module sq_search
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic [AW-1:0] slot_addr [DEPTH],
    input  logic [DW-1:0] slot_data [DEPTH],
    input  logic          slot_avld [DEPTH],
    input  logic          slot_dvld [DEPTH],
    input  logic [PW:0]   head,
    input  logic [PW:0]   ld_pos,
    input  logic [AW-1:0] ld_addr,
    output ld_outcome_e   outcome,
    output logic [DW-1:0] fwd_data
);
    logic [PW:0]   span;
    logic [PW-1:0] idx;

    assign span = ld_pos - head;

    // Walk from oldest to youngest; the last relevant slot decides.
    always_comb begin
        outcome  = LD_CACHE;
        fwd_data = '0;
        idx      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head[PW-1:0] + PW'(k);
            if ((PW+1)'(k) < span) begin
                if (!slot_avld[idx]) begin
                    outcome  = LD_WAIT;
                    fwd_data = '0;
                end else if (slot_addr[idx] == ld_addr) begin
                    if (slot_dvld[idx]) begin
                        outcome  = LD_FWD;
                        fwd_data = slot_data[idx];
                    end else begin
                        outcome  = LD_WAIT;
                        fwd_data = '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sq_drain_fsm.sv
module sq_drain_fsm
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [PW:0] head,
    input  logic [PW:0] ret,
    input  logic        dc_ack,
    output logic        dc_req,
    output logic        pop
);
    drain_st_e   state, state_nx;
    logic [PW:0] head_nx;

    assign head_nx = head + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= DR_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DR_IDLE: if (head != ret) state_nx = DR_BUSY;
            DR_BUSY: if (dc_ack && head_nx == ret) state_nx = DR_IDLE;
            default: state_nx = DR_IDLE;
        endcase
    end

    always_comb begin
        dc_req = 1'b0;
        pop    = 1'b0;
        unique case (state)
            DR_IDLE: ;
            DR_BUSY: begin
                dc_req = 1'b1;
                pop    = dc_ack;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/store_queue.sv
module store_queue
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    output logic [PW:0]   alloc_tag,
    output logic          full,
    input  logic          addr_en,
    input  logic [PW-1:0] addr_idx,
    input  logic [AW-1:0] addr_val,
    input  logic          data_en,
    input  logic [PW-1:0] data_idx,
    input  logic [DW-1:0] data_val,
    input  logic          retire_en,
    input  logic          flush_en,
    input  logic [PW:0]   flush_tail,
    input  logic [AW-1:0] ld_addr,
    input  logic [PW:0]   ld_pos,
    output logic [1:0]    ld_outcome,
    output logic [DW-1:0] ld_data,
    output logic          dc_req,
    output logic [AW-1:0] dc_addr,
    output logic [DW-1:0] dc_data,
    input  logic          dc_ack
);
    logic [AW-1:0] slot_addr [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];
    logic          slot_avld [DEPTH];
    logic          slot_dvld [DEPTH];

    logic [PW:0]   head, tail, ret;
    logic          alloc_go, pop;
    ld_outcome_e   outcome;

    sq_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (alloc_en),
        .flush_en   (flush_en),
        .flush_tail (flush_tail),
        .retire_req (retire_en),
        .pop        (pop),
        .head       (head),
        .tail       (tail),
        .ret        (ret),
        .full       (full),
        .alloc_go   (alloc_go)
    );

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                slot_avld[i] <= 1'b0;
                slot_dvld[i] <= 1'b0;
                slot_addr[i] <= '0;
                slot_data[i] <= '0;
            end else if (alloc_go && tail[PW-1:0] == PW'(i)) begin
                slot_avld[i] <= 1'b0;
                slot_dvld[i] <= 1'b0;
            end else begin
                if (addr_en && addr_idx == PW'(i)) begin
                    slot_avld[i] <= 1'b1;
                    slot_addr[i] <= addr_val;
                end
                if (data_en && data_idx == PW'(i)) begin
                    slot_dvld[i] <= 1'b1;
                    slot_data[i] <= data_val;
                end
            end
        end
    end

    sq_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_avld (slot_avld),
        .slot_dvld (slot_dvld),
        .head      (head),
        .ld_pos    (ld_pos),
        .ld_addr   (ld_addr),
        .outcome   (outcome),
        .fwd_data  (ld_data)
    );

    sq_drain_fsm #(.DEPTH(DEPTH)) u_drain (
        .clk    (clk),
        .rst_n  (rst_n),
        .head   (head),
        .ret    (ret),
        .dc_ack (dc_ack),
        .dc_req (dc_req),
        .pop    (pop)
    );

    assign alloc_tag  = tail;
    assign ld_outcome = outcome;
    assign dc_addr    = slot_addr[head[PW-1:0]];
    assign dc_data    = slot_data[head[PW-1:0]];
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW:0]   head,
    input logic [PW:0]   tail,
    input logic [PW:0]   ret,
    input logic          alloc_en,
    input logic          full,
    input logic          flush_en,
    input logic [PW:0]   flush_tail,
    input logic          dc_req,
    input logic          dc_ack,
    input logic [AW-1:0] dc_addr,
    input logic [DW-1:0] dc_data,
    input logic [1:0]    ld_outcome
);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PW+1)'(tail - head) <= (PW+1)'(DEPTH));

    // R2
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_en && !flush_en) |=> $stable(tail));

    // R8
    drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_req && dc_ack) |=> (head == $past(head) + 1'b1));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_req && !dc_ack) |=> (dc_req && $stable(dc_addr) && $stable(dc_data)));

    // R11
    retired_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dc_req |-> (head != ret));

    // R10
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> (tail == $past(flush_tail)));

    // R3
    outcome_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_outcome != 2'd3);
endmodule

bind store_queue sq_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .head       (head),
    .tail       (tail),
    .ret        (ret),
    .alloc_en   (alloc_en),
    .full       (full),
    .flush_en   (flush_en),
    .flush_tail (flush_tail),
    .dc_req     (dc_req),
    .dc_ack     (dc_ack),
    .dc_addr    (dc_addr),
    .dc_data    (dc_data),
    .ld_outcome (ld_outcome)
);

// File: tb/sim_store_queue.sv
module sim_store_queue;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_en = 1'b0;
    logic [3:0]  alloc_tag;
    logic        full;
    logic        addr_en = 1'b0;
    logic [2:0]  addr_idx = '0;
    logic [31:0] addr_val = '0;
    logic        data_en = 1'b0;
    logic [2:0]  data_idx = '0;
    logic [31:0] data_val = '0;
    logic        retire_en = 1'b0;
    logic        flush_en = 1'b0;
    logic [3:0]  flush_tail = '0;
    logic [31:0] ld_addr = '0;
    logic [3:0]  ld_pos = '0;
    logic [1:0]  ld_outcome;
    logic [31:0] ld_data;
    logic        dc_req;
    logic [31:0] dc_addr;
    logic [31:0] dc_data;
    logic        dc_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] exp_q[$];
    logic [31:0] m_addr [8];
    logic [31:0] m_data [8];
    int m_ret = 0;

    always #(PERIOD/2) clk = ~clk;

    store_queue u0 (
        .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_tag(alloc_tag),
        .full(full), .addr_en(addr_en), .addr_idx(addr_idx), .addr_val(addr_val),
        .data_en(data_en), .data_idx(data_idx), .data_val(data_val),
        .retire_en(retire_en), .flush_en(flush_en), .flush_tail(flush_tail),
        .ld_addr(ld_addr), .ld_pos(ld_pos), .ld_outcome(ld_outcome),
        .ld_data(ld_data), .dc_req(dc_req), .dc_addr(dc_addr),
        .dc_data(dc_data), .dc_ack(dc_ack)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic alloc(input int n);
        alloc_en = 1'b1;
        repeat (n) tick();
        alloc_en = 1'b0;
    endtask

    task automatic put_addr(input int slot, input logic [31:0] a);
        addr_en = 1'b1; addr_idx = 3'(slot); addr_val = a;
        m_addr[slot] = a;
        tick();
        addr_en = 1'b0;
    endtask

    task automatic put_data(input int slot, input logic [31:0] d);
        data_en = 1'b1; data_idx = 3'(slot); data_val = d;
        m_data[slot] = d;
        tick();
        data_en = 1'b0;
    endtask

    // Driver: each retired store becomes an expected cache write.
    task automatic retire(input int n);
        retire_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({m_addr[m_ret % 8], m_data[m_ret % 8]});
            m_ret++;
            tick();
        end
        retire_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] a, input logic [3:0] pos,
                        input logic [1:0] eo, input logic [31:0] ed, input string req);
        ld_addr = a; ld_pos = pos;
        #1;
        check(ld_outcome == eo, req, 64'(ld_outcome), 64'(eo));
        if (eo == 2'd1)
            check(ld_data == ed, req, 64'(ld_data), 64'(ed));
    endtask

    // Monitor: compare every accepted cache write against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && dc_req && dc_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected drain", {dc_addr, dc_data}, 64'h0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check({dc_addr, dc_data} == e, "R8 drain order", {dc_addr, dc_data}, e);
            end
        end
    end

    initial begin
        #(PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        check(full == 1'b0, "R1 full", 64'(full), 0);
        check(dc_req == 1'b0, "R1 dc_req", 64'(dc_req), 0);
        check(alloc_tag == 4'd0, "R1 tail", 64'(alloc_tag), 0);
        look(32'h44, 4'd0, 2'd0, 0, "R1 lookup");

        alloc(5);
        check(alloc_tag == 4'd5, "R2 tag advance", 64'(alloc_tag), 5);
        look(32'h44, 4'd5, 2'd2, 0, "R6 all unresolved");
        look(32'h44, 4'd0, 2'd0, 0, "R4 load older than all");

        put_addr(0, 32'h44); put_data(0, 32'hA0);
        put_addr(1, 32'h20); put_data(1, 32'hA1);
        put_addr(2, 32'h44);
        put_addr(4, 32'h20); put_data(4, 32'hA4);

        look(32'h20, 4'd2, 2'd1, 32'hA1, "R3 forward s1");
        look(32'h44, 4'd2, 2'd1, 32'hA0, "R3 forward s0");
        look(32'h44, 4'd3, 2'd2, 0, "R7 match without data");
        look(32'h20, 4'd5, 2'd1, 32'hA4, "R6 match younger than unresolved");
        look(32'h20, 4'd4, 2'd2, 0, "R6 unresolved younger than match");
        look(32'h30, 4'd3, 2'd0, 0, "R5 no match");
        look(32'h20, 4'd1, 2'd0, 0, "R4 younger store ignored");
        put_data(2, 32'hA2);
        look(32'h44, 4'd3, 2'd1, 32'hA2, "R3 youngest older s2");
        put_addr(3, 32'h50); put_data(3, 32'hA3);

        alloc(3);
        check(full == 1'b1, "R2 full", 64'(full), 1);
        alloc(1);
        check(alloc_tag == 4'd8, "R2 alloc when full", 64'(alloc_tag), 8);

        put_addr(5, 32'h70); put_data(5, 32'hA5);
        put_addr(6, 32'h60); put_data(6, 32'hB6);
        look(32'h60, 4'd7, 2'd1, 32'hB6, "R3 pre-rewind");
        flush_en = 1'b1; flush_tail = 4'd6;
        tick();
        flush_en = 1'b0;
        check(alloc_tag == 4'd6, "R10 tail rewound", 64'(alloc_tag), 6);
        check(full == 1'b0, "R10 full cleared", 64'(full), 0);
        alloc(1);
        look(32'h60, 4'd7, 2'd2, 0, "R10 squashed slot gone");

        // Drain with the cache stalled, then released.
        dc_ack = 1'b0;
        retire(3);
        repeat (3) tick();
        check(dc_req == 1'b1, "R8 request raised", 64'(dc_req), 1);
        check(dc_addr == 32'h44, "R8 head held", 64'(dc_addr), 64'h44);
        dc_ack = 1'b1;
        repeat (10) tick();
        check(exp_q.size() == 0, "R8 drained", 64'(exp_q.size()), 0);
        look(32'h44, 4'd3, 2'd0, 0, "R9 drained store not searched");

        put_addr(6, 32'h80); put_data(6, 32'hA6);
        retire(4);
        retire_en = 1'b1;
        repeat (2) tick();
        retire_en = 1'b0;
        alloc(1);
        put_addr(7, 32'h90); put_data(7, 32'hA7);
        repeat (10) tick();
        check(exp_q.size() == 0, "R11 retired drained", 64'(exp_q.size()), 0);
        check(dc_req == 1'b0, "R11 extra retire ignored", 64'(dc_req), 0);
        check(alloc_tag == 4'd8, "R2 tag after wrap", 64'(alloc_tag), 8);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule